// File: doc/BRIEF.md
# Key-Unlocked Memory Erase Controller

This block clears an on-chip memory of a configurable number of words by writing zero to every word, one word per cycle. The erase is launched by a start bit in a small control register. The start bit is guarded by a two-byte unlock key, which software writes to an 8-bit key register. The key must be presented again before every erase.

Software reaches the block through a narrow register write port with a one-bit register select. The key register is at select 0 and the control register is at select 1. The read port is combinational. During an erase the block drives a simple word-addressed memory write port: an enable, an address and the data. It reports progress through a busy bit and through the start bit, which clears itself when the sweep ends.

Top module: `keyed_wipe`

## Requirements
- R1: After reset busy is 0, the memory write enable is 0, and both registers read as 0x00.
- R2: A write of 0xCA to the key register followed directly by a write of 0x53 to the key register unlocks the block. A control write with bit 0 set then starts an erase, and busy reads 1 in the next cycle.
- R3: Any key write that does not complete the sequence locks the block again. This covers a first key other than 0xCA, a second key other than 0x53, and any key write other than 0xCA while unlocked. A key write of 0xCA always starts a new sequence, so 0xCA, 0xCA, 0x53 unlocks, while 0xCA, 0x12, 0x53 does not.
- R4: A control write with bit 0 set while the block is locked is ignored: busy stays 0 and nothing is written to memory.
- R5: The erase writes zero to the word addresses 0, 1, ..., WORDS-1 in consecutive cycles, one word per cycle. The first write falls in the cycle after the start write.
- R6: While an erase is in progress, control read bit 1 (busy) and control read bit 0 (start) both read 1.
- R7: Busy stays high for exactly WORDS cycles. The start bit clears itself at the same edge that busy falls, and no memory write follows.
- R8: Starting an erase consumes the unlock, so a second start write without a fresh key sequence is ignored.
- R9: A start write during an erase is ignored, even when the key sequence has been written again. It neither extends nor restarts the sweep, and it does not consume the unlock, so a start write after the sweep begins a new erase.
- R10: The key register always reads back as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 selects the key register, 1 selects the control register |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for the register picked by regSel |
| memWrEn | output | 1 | Memory write enable, high for each erase write |
| memAddr | output | ADDR_W | Word address of the erase write |
| memWrData | output | DATA_W | Erase write data, always zero |

## Verification
The case that matters is a start request arriving in the same cycle as a sweep step. The bench starts an erase, writes the full key sequence while the sweep is running, and then issues a start write in the middle of the sweep. It judges the outcome at the memory port: busy must last exactly WORDS cycles, with no restart at address 0. It then checks that the unlock survived the ignored request, by confirming that a start write after the sweep launches a clean second erase.

// File: rtl/keyed_wipe_pkg.sv
package keyed_wipe_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } keyState_t;

  typedef struct packed {
    logic clearAddr;
    logic stepAddr;
  } sweepCmd_t;
endpackage

// File: rtl/keyed_wipe_ctrl.sv
module keyed_wipe_ctrl
  import keyed_wipe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyWr,
  input  logic       ctrlWr,
  input  logic [7:0] wrData,
  input  logic       lastWord,
  output logic       busy,
  output sweepCmd_t  cmd
);
  keyState_t keyState;
  logic      startReq;
  logic      startOk;

  assign startReq = ctrlWr && wrData[0];
  assign startOk  = startReq && !busy && (keyState == KEY_OPEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyState <= KEY_LOCKED;
    end else if (startOk) begin
      keyState <= KEY_LOCKED;
    end else if (keyWr) begin
      if (wrData == KEY_FIRST)
        keyState <= KEY_HALF;
      else if (wrData == KEY_SECOND && keyState == KEY_HALF)
        keyState <= KEY_OPEN;
      else
        keyState <= KEY_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      busy <= 1'b0;
    else if (startOk)
      busy <= 1'b1;
    else if (busy && lastWord)
      busy <= 1'b0;
  end

  always_comb begin
    cmd.clearAddr = startOk;
    cmd.stepAddr  = busy;
  end

  // R4: a start request while locked leaves the block idle
  p_locked_start_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && keyState != KEY_OPEN) |=> !busy);

  // R8: an erase always begins with the key consumed
  p_unlock_consumed_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> keyState == KEY_LOCKED);

  // R9: a start request mid-sweep keeps the sweep running and the key state unchanged
  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastWord && ctrlWr) |=> (busy && $stable(keyState)));
endmodule

// File: rtl/keyed_wipe_dp.sv
module keyed_wipe_dp
  import keyed_wipe_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweepCmd_t         cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrData,
  output logic              lastWord
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

  assign lastWord = (addr == LAST);
  assign wrData   = '0;

  always_ff @(posedge clk) begin
    if (!rstN)
      addr <= '0;
    else if (cmd.clearAddr)
      addr <= '0;
    else if (cmd.stepAddr && !lastWord)
      addr <= addr + ADDR_W'(1);
  end
endmodule

// File: rtl/keyed_wipe.sv
module keyed_wipe
  import keyed_wipe_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32,
  localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

  logic      busy;
  logic      lastWord;
  sweepCmd_t cmd;

  keyed_wipe_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .keyWr    (regWrEn && !regSel),
    .ctrlWr   (regWrEn && regSel),
    .wrData   (regWrData),
    .lastWord (lastWord),
    .busy     (busy),
    .cmd      (cmd)
  );

  keyed_wipe_dp #(.WORDS(WORDS), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .addr     (memAddr),
    .wrData   (memWrData),
    .lastWord (lastWord)
  );

  assign memWrEn   = busy;
  assign regRdData = regSel ? {6'b0, busy, busy} : 8'h00;

  // R5: the sweep opens at word zero
  p_sweep_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrEn) |-> memAddr == '0);

  // R5: consecutive writes go to consecutive addresses
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> memAddr == $past(memAddr) + ADDR_W'(1));

  // R7: the sweep closes right after the last word
  p_sweep_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWrEn) |-> $past(memAddr) == LAST);
endmodule

// File: tb/keyed_wipe_test.sv
module keyed_wipe_test;
  localparam int WORDS  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = $clog2(WORDS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regSel = 1'b0;
  logic [7:0]        regWrData = 8'h00;
  logic [7:0]        regRdData;
  logic              memWrEn;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWrData;

  int checks = 0;
  int fails = 0;
  int busyCycles = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] model [WORDS];

  always #2 clk = ~clk;

  keyed_wipe #(.WORDS(WORDS), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData)
  );

  always @(posedge clk) begin
    if (memWrEn) begin
      model[memAddr] <= memWrData;
      busyCycles <= busyCycles + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [7:0] data);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic sel, output logic [7:0] data);
    regSel = sel;
    #1;
    data = regRdData;
  endtask

  task automatic fillModel();
    for (int i = 0; i < WORDS; i++) model[i] = DATA_W'(32'hA5A5_0000 + i);
  endtask

  task automatic unlock();
    regWrite(1'b0, 8'hCA);
    regWrite(1'b0, 8'h53);
  endtask

  task automatic expectIdle(input string req);
    logic [7:0] rd;
    regRead(1'b1, rd);
    check(rd == 8'h00 && !memWrEn, req, {rd, 7'b0, memWrEn}, 0);
  endtask

  task automatic checkSweep(input string tag);
    logic [7:0] rd;
    for (int i = 0; i < WORDS; i++) begin
      regRead(1'b1, rd);
      check(memWrEn && memAddr == ADDR_W'(i) && memWrData == '0,
            {tag, " R5 write slot"}, {memWrEn, memAddr}, {1'b1, ADDR_W'(i)});
      check(rd == 8'h03, {tag, " R6 busy/start read"}, rd, 8'h03);
      @(negedge clk);
    end
    regRead(1'b1, rd);
    check(rd == 8'h00 && !memWrEn, {tag, " R7 self-clear"}, {rd, 7'b0, memWrEn}, 0);
    for (int i = 0; i < WORDS; i++)
      check(model[i] == '0, {tag, " R5 word zeroed"}, model[i], 0);
  endtask

  task automatic t_reset();
    logic [7:0] rd;
    expectIdle("R1 control after reset");
    regRead(1'b0, rd);
    check(rd == 8'h00, "R1 key after reset", rd, 0);
  endtask

  task automatic t_locked_start();
    regWrite(1'b1, 8'h01);
    expectIdle("R4 start while locked");
    @(negedge clk);
    expectIdle("R4 still idle");
  endtask

  task automatic t_unlock_erase();
    fillModel();
    unlock();
    regWrite(1'b1, 8'h01);
    checkSweep("R2 unlocked erase");
  endtask

  task automatic t_consumed();
    regWrite(1'b1, 8'h01);
    expectIdle("R8 unlock consumed");
  endtask

  task automatic t_wrong_keys();
    regWrite(1'b0, 8'hCA); regWrite(1'b0, 8'h12); regWrite(1'b0, 8'h53);
    regWrite(1'b1, 8'h01);
    expectIdle("R3 CA,12,53 stays locked");
    regWrite(1'b0, 8'h53);
    regWrite(1'b1, 8'h01);
    expectIdle("R3 lone 53 stays locked");
    regWrite(1'b0, 8'h53); regWrite(1'b0, 8'hCA);
    regWrite(1'b1, 8'h01);
    expectIdle("R3 reversed order stays locked");
    unlock();
    regWrite(1'b0, 8'h77);
    regWrite(1'b1, 8'h01);
    expectIdle("R3 wrong key after unlock relocks");
    fillModel();
    regWrite(1'b0, 8'hCA); regWrite(1'b0, 8'hCA); regWrite(1'b0, 8'h53);
    regWrite(1'b1, 8'h01);
    checkSweep("R3 CA,CA,53 unlocks");
  endtask

  task automatic t_busy_start();
    logic [7:0] rd;
    fillModel();
    unlock();
    busyCycles = 0;
    regWrite(1'b1, 8'h01);
    unlock();
    regWrite(1'b1, 8'h01);
    regRead(1'b1, rd);
    check(rd == 8'h03 && memAddr == ADDR_W'(3), "R9 sweep continues", {rd, memAddr}, {8'h03, ADDR_W'(3)});
    while (memWrEn) @(negedge clk);
    check(busyCycles == WORDS, "R7 R9 busy length", busyCycles, WORDS);
    fillModel();
    regWrite(1'b1, 8'h01);
    checkSweep("R9 unlock kept after ignored start");
  endtask

  task automatic t_key_read();
    logic [7:0] rd;
    regWrite(1'b0, 8'hCA);
    regRead(1'b0, rd);
    check(rd == 8'h00, "R10 key reads zero", rd, 0);
    regWrite(1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_start();
    t_unlock_erase();
    t_consumed();
    t_wrong_keys();
    t_busy_start();
    t_key_read();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule